// File: doc/BRIEF.md
# Single-Cycle Processor Core with Register-Indexed Store

This block is a small single-cycle 32-bit processor core for a load/store instruction set. Every instruction completes in one clock. The core runs five register-to-register ALU operations (add, subtract, and, or, signed set-less-than), a word load, a word store and a branch-if-equal. It also runs one extra instruction, an indexed store. The indexed store uses the register format and takes its memory address from the sum of two registers rather than from a base register plus a constant.

The instruction and data memories sit inside the block. While reset is held, a preload port fills them. After reset is released, the core fetches from address zero. An inspection port reads any data-memory word combinationally, and the store outputs show the address and data of the store happening in the current cycle. This lets a host fill a program and its operands, let it run, and read back the results.

Top module: `idx_store_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all registers become 0. `pc_o` reads 0 while reset is held.
- R2: Register 0 always reads as zero. An instruction that names register 0 as its destination leaves it zero.
- R3: The indexed store (opcode 0x00, funct 0x2B, with rs in bits 25:21, rt in bits 20:16 and rd in bits 15:11) writes to the data-memory word whose index is bits [MEM_AW+1:2] of the 32-bit sum reg[rs]+reg[rt]. The two low address bits are dropped, so a misaligned sum still writes the containing word.
- R4: The indexed store writes no register, including the register named in its rd field.
- R5: The indexed store writes the full 32-bit value of reg[rt] and raises `st_en_o` in that cycle.
- R6: Register-format instructions (opcode 0x00) with funct 0x20, 0x22, 0x24, 0x25 and 0x2A write reg[rs]+reg[rt], reg[rs]-reg[rt], the AND, the OR, or a signed less-than result (1 or 0) into reg[rd].
- R7: A load (opcode 0x23) writes into reg[rt] the memory word at reg[rs] plus the sign-extended 16-bit offset. A store (opcode 0x2B) writes reg[rt] to that address.
- R8: Each cycle the PC advances by 4. A branch (opcode 0x04) whose two register operands are equal instead loads PC+4 plus the sign-extended offset shifted left by two.
- R9: The preload port writes memory only while `rst` is high. A preload strobe with `rst` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; also opens the preload port |
| ld_en | input | 1 | Preload write strobe |
| ld_to_imem | input | 1 | Preload target: 1 selects instruction memory, 0 selects data memory |
| ld_addr | input | MEM_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| peek_addr | input | MEM_AW | Data-memory word index for inspection |
| peek_data | output | 32 | Data-memory word at `peek_addr` (combinational) |
| pc_o | output | 32 | Current program counter |
| st_en_o | output | 1 | A store instruction is executing this cycle |
| st_addr_o | output | 32 | Byte address computed by the ALU this cycle |
| st_data_o | output | 32 | Value of the second read register (the store data) |

## Verification
The assertions assume that the instruction memory holds only well-formed words from the supported set, so the next-PC check and the indexed-store checks see meaningful operands once reset has ended. They also assume that the preload port is quiet while the core runs, apart from the deliberate strobe that R9 exercises. The stimulus keeps to this. One fixed program, built from the encodings in the requirements, is loaded once and ends in a branch-to-self loop. Each run changes only the data operands: a sweep over every pair from a set of signed corner values, with the indexed-store offset varied so that both aligned and misaligned sums occur.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_CODE_ADD   = 6'h20;
  localparam logic [5:0] FN_CODE_SUB   = 6'h22;
  localparam logic [5:0] FN_CODE_AND   = 6'h24;
  localparam logic [5:0] FN_CODE_OR    = 6'h25;
  localparam logic [5:0] FN_CODE_SLT   = 6'h2A;
  localparam logic [5:0] FN_CODE_IDXST = 6'h2B;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_we;
    logic    mem_rd;
    logic    mem_we;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/isc_main_dec.sv
`timescale 1ns/1ps
module isc_main_dec import isc_pkg::*; (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{reg_dst: 1'b0, alu_src: 1'b0, mem_to_reg: 1'b0, reg_we: 1'b0,
             mem_rd: 1'b0, mem_we: 1'b0, branch: 1'b0, alu_op: AOP_ADD};
    case (opcode)
      OP_RTYPE: begin
        if (funct == FN_CODE_IDXST) begin
          // indexed store: register operand as offset, no write-back
          ctrl.mem_we = 1'b1;
          ctrl.alu_op = AOP_ADD;
        end else begin
          ctrl.reg_dst = 1'b1;
          ctrl.reg_we  = 1'b1;
          ctrl.alu_op  = AOP_FUNCT;
        end
      end
      OP_LW: begin
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_we     = 1'b1;
        ctrl.mem_rd     = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_src = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = AOP_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/isc_alu_ctl.sv
`timescale 1ns/1ps
module isc_alu_ctl import isc_pkg::*; (
  input  alu_op_e    alu_op,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  always_comb begin
    fn = ALU_ADD;
    case (alu_op)
      AOP_ADD: fn = ALU_ADD;
      AOP_SUB: fn = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_CODE_SUB: fn = ALU_SUB;
          FN_CODE_AND: fn = ALU_AND;
          FN_CODE_OR:  fn = ALU_OR;
          FN_CODE_SLT: fn = ALU_SLT;
          default:     fn = ALU_ADD;
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/isc_alu.sv
`timescale 1ns/1ps
module isc_alu import isc_pkg::*; #(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    y = '0;
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y[0] = ($signed(a) < $signed(b));
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/isc_regfile.sv
`timescale 1ns/1ps
module isc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int NRD  = 2,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [RAW-1:0] raddr [NRD],
  output logic [W-1:0]   rdata [NRD]
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/idx_store_cpu.sv
`timescale 1ns/1ps
module idx_store_cpu import isc_pkg::*; #(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_to_imem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [XLEN-1:0]   peek_data,
  output logic [XLEN-1:0]   pc_o,
  output logic              st_en_o,
  output logic [XLEN-1:0]   st_addr_o,
  output logic [XLEN-1:0]   st_data_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int NREG  = 32;
  localparam int RAW   = $clog2(NREG);

  logic [XLEN-1:0] imem [DEPTH];
  logic [XLEN-1:0] dmem [DEPTH];
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] instr;

  // instruction fields
  logic [5:0]     opcode, funct;
  logic [RAW-1:0] f_rs, f_rt, f_rd;
  logic [XLEN-1:0] simm;

  ctrl_t           ctrl;
  alu_fn_e         fn;
  logic [XLEN-1:0] rd_a, rd_b, alu_b, alu_y, wb_data, dm_rdata;
  logic            alu_zero, rf_we;
  logic [RAW-1:0]  wr_reg;
  logic [RAW-1:0]  rf_raddr [2];
  logic [XLEN-1:0] rf_rdata [2];

  logic [XLEN-1:0] pc_plus4, br_target;
  logic            br_take;

  logic              dm_we;
  logic [MEM_AW-1:0] dm_waddr, dm_raddr;
  logic [XLEN-1:0]   dm_wdata;
  logic              unused_bits;

  // fetch
  assign instr  = imem[pc[MEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign f_rs   = instr[25:21];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign funct  = instr[5:0];
  assign simm   = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign unused_bits = ^instr[10:6];

  // control
  isc_main_dec u_dec (.opcode(opcode), .funct(funct), .ctrl(ctrl));
  isc_alu_ctl  u_actl (.alu_op(ctrl.alu_op), .funct(funct), .fn(fn));

  // register file
  assign rf_raddr[0] = f_rs;
  assign rf_raddr[1] = f_rt;
  assign rd_a   = rf_rdata[0];
  assign rd_b   = rf_rdata[1];
  assign wr_reg = ctrl.reg_dst ? f_rd : f_rt;
  assign rf_we  = ctrl.reg_we & ~rst;

  isc_regfile #(.NREG(NREG), .W(XLEN), .NRD(2)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(wr_reg), .wdata(wb_data),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  // execute
  assign alu_b = ctrl.alu_src ? simm : rd_b;
  isc_alu #(.W(XLEN)) u_alu (.a(rd_a), .b(alu_b), .fn(fn), .y(alu_y), .zero(alu_zero));

  // data memory: one write port shared by preload and core, async reads
  assign dm_raddr = alu_y[MEM_AW+1:2];
  assign dm_we    = rst ? (ld_en & ~ld_to_imem) : ctrl.mem_we;
  assign dm_waddr = rst ? ld_addr : dm_raddr;
  assign dm_wdata = rst ? ld_data : rd_b;

  always_ff @(posedge clk) begin
    if (dm_we) dmem[dm_waddr] <= dm_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst && ld_en && ld_to_imem) imem[ld_addr] <= ld_data;
  end

  assign dm_rdata  = ctrl.mem_rd ? dmem[dm_raddr] : '0;
  assign peek_data = dmem[peek_addr];
  assign wb_data   = ctrl.mem_to_reg ? dm_rdata : alu_y;

  // next PC
  assign pc_plus4  = pc + XLEN'(4);
  assign br_target = pc_plus4 + (simm << 2);
  assign br_take   = ctrl.branch & alu_zero;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= br_take ? br_target : pc_plus4;
  end

  assign pc_o      = pc;
  assign st_en_o   = ctrl.mem_we & ~rst;
  assign st_addr_o = alu_y;
  assign st_data_o = rd_b;
endmodule

// File: rtl/isc_chk.sv
`timescale 1ns/1ps
module isc_chk import isc_pkg::*; (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rd_a,
  input logic [XLEN-1:0] rd_b,
  input logic            rf_we,
  input logic            st_en,
  input logic [XLEN-1:0] st_addr,
  input logic [XLEN-1:0] st_data,
  input logic [XLEN-1:0] pc
);
  logic            is_idx, is_beq, eq_ops;
  logic [XLEN-1:0] off_sh;

  assign is_idx = (instr[31:26] == OP_RTYPE) && (instr[5:0] == FN_CODE_IDXST);
  assign is_beq = (instr[31:26] == OP_BEQ);
  assign eq_ops = (rd_a == rd_b);
  assign off_sh = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

  // R3: indexed store address is the sum of both register operands
  a_r3_idx_addr: assert property (@(posedge clk) disable iff (rst)
    is_idx |-> st_addr == rd_a + rd_b);

  // R5: indexed store drives rt value and enables the write
  a_r5_idx_data: assert property (@(posedge clk) disable iff (rst)
    is_idx |-> (st_en && st_data == rd_b));

  // R4: no register write-back for the indexed store
  a_r4_idx_no_wb: assert property (@(posedge clk) disable iff (rst)
    is_idx |-> !rf_we);

  // R2: register zero reads as zero
  a_r2_r0_zero: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> rd_a == '0);

  // R8: sequential or branch next PC
  a_r8_next_pc: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == ($past(is_beq && eq_ops) ? $past(pc) + 4 + $past(off_sh)
                                            : $past(pc) + 4));
endmodule

bind idx_store_cpu isc_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .rd_a(rd_a), .rd_b(rd_b),
  .rf_we(rf_we), .st_en(st_en_o), .st_addr(st_addr_o),
  .st_data(st_data_o), .pc(pc_o)
);

// File: tb/tb_idx_store_cpu.sv
`timescale 1ns/1ps
module tb_idx_store_cpu;
  localparam int MEM_AW = 6;
  localparam int NPROG  = 25;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_en = 1'b0;
  logic              ld_to_imem = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [31:0]       ld_data = '0;
  logic [MEM_AW-1:0] peek_addr = '0;
  logic [31:0]       peek_data, pc_o, st_addr_o, st_data_o;
  logic              st_en_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  idx_store_cpu #(.MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_to_imem(ld_to_imem),
    .ld_addr(ld_addr), .ld_data(ld_data), .peek_addr(peek_addr),
    .peek_data(peek_data), .pc_o(pc_o), .st_en_o(st_en_o),
    .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  function automatic logic [31:0] rt_op(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] it_op(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load(input bit to_imem, input int addr, input logic [31:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_to_imem = to_imem; ld_addr = MEM_AW'(addr); ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input int addr, output logic [31:0] v);
    peek_addr = MEM_AW'(addr);
    #1;
    v = peek_data;
  endtask

  logic [31:0] prog [NPROG];
  logic [31:0] vals [7];

  initial begin
    prog[0]  = it_op(6'h23, 0, 1, 16'd0);
    prog[1]  = it_op(6'h23, 0, 2, 16'd4);
    prog[2]  = it_op(6'h23, 0, 8, 16'd8);
    prog[3]  = it_op(6'h23, 0, 9, 16'd12);
    prog[4]  = rt_op(1, 2, 3, 6'h20);
    prog[5]  = rt_op(1, 2, 4, 6'h22);
    prog[6]  = rt_op(1, 2, 5, 6'h24);
    prog[7]  = rt_op(1, 2, 6, 6'h25);
    prog[8]  = rt_op(1, 2, 7, 6'h2A);
    prog[9]  = it_op(6'h2B, 0, 3, 16'd16);
    prog[10] = it_op(6'h2B, 0, 4, 16'd20);
    prog[11] = it_op(6'h2B, 0, 5, 16'd24);
    prog[12] = it_op(6'h2B, 0, 6, 16'd28);
    prog[13] = it_op(6'h2B, 0, 7, 16'd32);
    prog[14] = rt_op(8, 9, 3, 6'h2B);           // indexed store, rd names r3
    prog[15] = it_op(6'h2B, 0, 3, 16'd36);
    prog[16] = rt_op(1, 2, 0, 6'h20);           // write to r0
    prog[17] = it_op(6'h2B, 0, 0, 16'd40);
    prog[18] = it_op(6'h04, 1, 1, 16'd1);       // always taken
    prog[19] = rt_op(1, 2, 10, 6'h20);          // skipped
    prog[20] = it_op(6'h04, 1, 2, 16'd1);       // taken when a==b
    prog[21] = rt_op(1, 1, 11, 6'h20);
    prog[22] = it_op(6'h2B, 0, 10, 16'd44);
    prog[23] = it_op(6'h2B, 0, 11, 16'd48);
    prog[24] = it_op(6'h04, 0, 0, 16'hFFFF);    // branch to self

    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    vals[6] = 32'h0000_1234;

    for (int w = 0; w < NPROG; w++) load(1'b1, w, prog[w]);

    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        automatic int k = i * 7 + j;
        automatic logic [31:0] a = vals[i];
        automatic logic [31:0] b = vals[j];
        automatic logic [31:0] off = 32'(4 * (k % 8) + (k % 3));
        automatic logic [31:0] v;
        @(negedge clk);
        rst = 1'b1;
        load(1'b0, 0, a);
        load(1'b0, 1, b);
        load(1'b0, 2, 32'd64);
        load(1'b0, 3, off);
        chk("R1 pc in reset", pc_o, 32'd0);
        rst = 1'b0;
        repeat (32) @(negedge clk);
        chk("R8 halt pc", pc_o, 32'd96);
        peek(4, v);  chk("R6 add / R7 sw", v, a + b);
        peek(5, v);  chk("R6 sub", v, a - b);
        peek(6, v);  chk("R6 and", v, a & b);
        peek(7, v);  chk("R6 or", v, a | b);
        peek(8, v);  chk("R6 slt", v, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        peek(16 + (k % 8), v); chk("R3 R5 indexed store word", v, off);
        peek(9, v);  chk("R4 rd untouched by indexed store", v, a + b);
        peek(10, v); chk("R2 r0 stays zero", v, 32'd0);
        peek(11, v); chk("R8 R1 skipped instr leaves reset reg", v, 32'd0);
        peek(12, v); chk("R8 beq eq/neq", v, (a == b) ? 32'd0 : a + a);
        // R9: preload strobe with reset low must not write
        @(negedge clk);
        ld_en = 1'b1; ld_to_imem = 1'b0; ld_addr = MEM_AW'(4); ld_data = 32'hDEAD_BEEF;
        @(negedge clk);
        ld_en = 1'b0;
        peek(4, v);  chk("R9 preload ignored when running", v, a + b);
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule